// File: doc/BRIEF.md
# Interrupt Register Access Trap Checker

This block decides, in the same cycle, whether a processor access to one of the interrupt controller's per-core system registers may proceed or must be trapped. Each register belongs to a class that ties it to the normal interrupt line, the fast interrupt line, or both. The routing bits for these lines in the secure configuration register and the hypervisor configuration register, together with the current exception level, security state and execution width, pick the verdict.

The verdict is either OK, a trap taken to the highest exception level, or a plain trap. The plain trap is used when the highest level does not run in 64-bit state. The block is purely combinational. It sits beside the register decode stage, which feeds it the class of the register being addressed and acts on the 2-bit verdict. Taking the exception itself is left to the consumer.

Top module: `irq_acc_trap`

## Requirements
- R1: The verdict is encoded on 2 bits as 0 = OK, 1 = plain trap, 2 = trap to the highest level (EL3). The value 3 is never produced.
- R2: The class input uses bit 0 for the normal interrupt line and bit 1 for the fast interrupt line, so 01 = IRQ-only, 10 = FIQ-only and 11 = both. Class 00 names no line and always gives OK.
- R3: The check applies only when every line named by the class has its routing bit set in `scr_route` (bit 0 IRQ, bit 1 FIQ). Otherwise the verdict is OK whatever the other inputs are.
- R4: At EL1 with `sec_below_el3` set, an applicable check gives a trap to EL3.
- R5: At EL1 in non-secure state, an applicable check gives a trap to EL3 when none of the lines named by the class has its bit set in `hcr_route` (bit 0 IMO, bit 1 FMO). Otherwise it gives OK.
- R6: At EL2 an applicable check always gives a trap to EL3.
- R7: At EL3 an applicable check gives a trap to EL3 only when `cur_aa64` and `el3_or_mon` are both clear. Otherwise it gives OK.
- R8: When `el3_aa64` is clear, every trap-to-EL3 verdict is reported as a plain trap (1) instead. The value 2 never appears in that case.
- R9: A `cur_el` value of 0 is an illegal combination and gives OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_class | input | 2 | Lines the addressed register belongs to (bit 0 IRQ, bit 1 FIQ) |
| cur_el | input | 2 | Current exception level, 1 to 3 |
| sec_below_el3 | input | 1 | Core is in secure state below EL3 |
| scr_route | input | 2 | Secure configuration routing bits (bit 0 IRQ, bit 1 FIQ) |
| hcr_route | input | 2 | Hypervisor routing bits (bit 0 IMO, bit 1 FMO) |
| cur_aa64 | input | 1 | Current state is 64-bit |
| el3_or_mon | input | 1 | Executing at 64-bit EL3 or in 32-bit monitor mode |
| el3_aa64 | input | 1 | EL3 runs in 64-bit state |
| verdict | output | 2 | 0 OK, 1 plain trap, 2 trap to EL3 |

## Verification
The bench sweeps all 4096 combinations of the twelve input bits and compares each verdict with a value worked out from the rules above. The class values separate the single-line gating from the both-lines gating: IRQ-only and FIQ-only need one routing bit, the combined class needs both, and class 00 must never trap. The hypervisor bits at non-secure EL1 show whether one set bit is enough to allow the access for the combined class. The EL3 width and monitor flags separate the two trap codes and the EL3 exemption. Level 0 and the never-used code 3 are checked on every pattern.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
  // number of interrupt lines a register class can name (IRQ, FIQ)
  localparam int LINE_N = 2;
  localparam int EL_W   = 2;
  localparam int VERD_W = 2;

  typedef enum logic [VERD_W-1:0] {
    VERD_OK       = 2'd0,
    VERD_TRAP     = 2'd1,
    VERD_TRAP_EL3 = 2'd2
  } verdict_e;

  localparam logic [EL_W-1:0] LVL_0 = 2'd0;
  localparam logic [EL_W-1:0] LVL_1 = 2'd1;
  localparam logic [EL_W-1:0] LVL_2 = 2'd2;
  localparam logic [EL_W-1:0] LVL_3 = 2'd3;
endpackage

// File: rtl/irq_acc_gate.sv
module irq_acc_gate
  import irq_acc_pkg::*;
#(
  parameter int LINES = LINE_N
) (
  input  logic [LINES-1:0] cls,
  input  logic [LINES-1:0] scr_route,
  output logic             applies
);
  logic [LINES-1:0] covered;

  // a line is covered when the class does not name it or its routing bit is set
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign covered[g] = !cls[g] || scr_route[g];
  end

  assign applies = (|cls) && (&covered);
endmodule

// File: rtl/irq_acc_level.sv
module irq_acc_level
  import irq_acc_pkg::*;
#(
  parameter int LINES = LINE_N
) (
  input  logic             applies,
  input  logic [LINES-1:0] cls,
  input  logic [EL_W-1:0]  cur_el,
  input  logic             sec_below_el3,
  input  logic [LINES-1:0] hcr_route,
  input  logic             cur_aa64,
  input  logic             el3_or_mon,
  output logic             wants_el3
);
  logic hyp_none;

  assign hyp_none = ~|(hcr_route & cls);

  always_comb begin
    wants_el3 = 1'b0;
    if (applies) begin
      unique case (cur_el)
        LVL_1:   wants_el3 = sec_below_el3 || hyp_none;
        LVL_2:   wants_el3 = 1'b1;
        LVL_3:   wants_el3 = !cur_aa64 && !el3_or_mon;
        default: wants_el3 = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (applies && cur_el == LVL_2)
      assert_el2_trap_R6: assert (wants_el3) else $error("R6 EL2 not trapped");
    if (cur_el == LVL_0)
      assert_el0_quiet_R9: assert (!wants_el3) else $error("R9 EL0 trapped");
  end
endmodule

// File: rtl/irq_acc_fold.sv
module irq_acc_fold
  import irq_acc_pkg::*;
(
  input  logic     wants_el3,
  input  logic     el3_aa64,
  output verdict_e verd
);
  always_comb begin
    if (!wants_el3)     verd = VERD_OK;
    else if (el3_aa64)  verd = VERD_TRAP_EL3;
    else                verd = VERD_TRAP;
  end
endmodule

// File: rtl/irq_acc_trap.sv
module irq_acc_trap
  import irq_acc_pkg::*;
(
  input  logic [1:0] acc_class,
  input  logic [1:0] cur_el,
  input  logic       sec_below_el3,
  input  logic [1:0] scr_route,
  input  logic [1:0] hcr_route,
  input  logic       cur_aa64,
  input  logic       el3_or_mon,
  input  logic       el3_aa64,
  output logic [1:0] verdict
);
  logic     applies;
  logic     wants_el3;
  verdict_e verd;

  irq_acc_gate #(.LINES(LINE_N)) u_gate (
    .cls       (acc_class),
    .scr_route (scr_route),
    .applies   (applies)
  );

  irq_acc_level #(.LINES(LINE_N)) u_level (
    .applies       (applies),
    .cls           (acc_class),
    .cur_el        (cur_el),
    .sec_below_el3 (sec_below_el3),
    .hcr_route     (hcr_route),
    .cur_aa64      (cur_aa64),
    .el3_or_mon    (el3_or_mon),
    .wants_el3     (wants_el3)
  );

  irq_acc_fold u_fold (
    .wants_el3 (wants_el3),
    .el3_aa64  (el3_aa64),
    .verd      (verd)
  );

  assign verdict = verd;

  always_comb begin
    assert_code_legal_R1: assert (verdict != 2'd3) else $error("R1 code 3");
    if (acc_class == 2'b00)
      assert_no_class_ok_R2: assert (verdict == VERD_OK) else $error("R2 trap");
    if (!applies)
      assert_gate_ok_R3: assert (verdict == VERD_OK) else $error("R3 trap");
    if (!el3_aa64)
      assert_fold_plain_R8: assert (verdict != VERD_TRAP_EL3) else $error("R8 el3 code");
  end
endmodule

// File: tb/irq_acc_trap_tb.sv
module irq_acc_trap_tb;
  logic clk;
  logic rst_n;
  logic [1:0] acc_class, cur_el, scr_route, hcr_route;
  logic sec_below_el3, cur_aa64, el3_or_mon, el3_aa64;
  logic [1:0] verdict;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  irq_acc_trap u_dut (
    .acc_class     (acc_class),
    .cur_el        (cur_el),
    .sec_below_el3 (sec_below_el3),
    .scr_route     (scr_route),
    .hcr_route     (hcr_route),
    .cur_aa64      (cur_aa64),
    .el3_or_mon    (el3_or_mon),
    .el3_aa64      (el3_aa64),
    .verdict       (verdict)
  );

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: verdict=%0d expected=%0d (cls=%b el=%0d sec=%b scr=%b hcr=%b a64=%b mon=%b e3a64=%b)",
               tag, got, exp, acc_class, cur_el, sec_below_el3, scr_route, hcr_route,
               cur_aa64, el3_or_mon, el3_aa64);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    finish_run();
  end

  initial begin
    logic gate, trap3;
    logic [1:0] exp;
    string tag;
    rst_n = 1'b0;
    acc_class = '0; cur_el = '0; scr_route = '0; hcr_route = '0;
    sec_below_el3 = 0; cur_aa64 = 0; el3_or_mon = 0; el3_aa64 = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset-time idle inputs", verdict, 2'd0);
    rst_n = 1'b1;
    for (int v = 0; v < 4096; v++) begin
      @(posedge clk);
      #1;
      {acc_class, cur_el, sec_below_el3, scr_route, hcr_route,
       cur_aa64, el3_or_mon, el3_aa64} = v[11:0];
      #1;
      gate  = (acc_class != 2'b00) && ((scr_route & acc_class) == acc_class);
      trap3 = 1'b0;
      if (acc_class == 2'b00)      tag = "R2";
      else if (cur_el == 2'd0)     tag = "R9";
      else if (!gate)              tag = "R3";
      else if (cur_el == 2'd1) begin
        if (sec_below_el3) begin tag = "R4"; trap3 = 1'b1; end
        else begin tag = "R5"; trap3 = ((hcr_route & acc_class) == 2'b00); end
      end
      else if (cur_el == 2'd2) begin tag = "R6"; trap3 = 1'b1; end
      else begin tag = "R7"; trap3 = !cur_aa64 && !el3_or_mon; end
      if (!gate) trap3 = 1'b0;
      if (!trap3)        exp = 2'd0;
      else if (el3_aa64) exp = 2'd2;
      else begin exp = 2'd1; tag = {tag, "+R8"}; end
      check(tag, verdict, exp);
      checks++;
      if (verdict == 2'd3) begin
        errors++;
        $display("FAIL R1: verdict=3 expected one of 0,1,2");
      end
    end
    finish_run();
  end
endmodule